// File: doc/BRIEF.md
# Level-2 Event Buffer Address Control

This block steers a bank of four level-2 readout buffers. Every level-1 accept fills one buffer, and the block names which one through a 2-bit fill pointer and a one-hot fill strobe. In run mode the fill pointer follows the trigger system's 2-bit buffer address, taken bit-inverted, and the trigger's accept fires the strobe. In test mode the pointer comes from a host-written control word, and a host write to a dedicated address acts as a fake accept in place of the trigger.

The readout side is independent of the fill side. The buffer read during data-acquisition readout is selected straight from two host address bits. Three active-low readout enables, one for each pair of towers, are driven low only while a host read to the readout window is in progress.

A single host cycle port (select, write flag, address, write data) carries control writes, fake accepts and readout reads. All outputs are registered.

Top module: `l2_evbuf_addr_ctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the block is in run mode with test pointer 0. `wr_addr` and `rd_addr` are 0, `fill_stb` is all zero and `rd_en_n` is all ones.
- R2: In run mode, `wr_addr` one cycle after an edge equals the bitwise inverse of `trig_addr` sampled at that edge.
- R3: A host write (`host_sel`=1, `host_write`=1) to address 0x00 loads the control word. Bit 0 selects the mode (1 = test, 0 = run) and bits 2:1 hold the test pointer. The new setting governs the edge after the write, so in test mode `wr_addr` shows the pointer two cycles after the write.
- R4: In run mode, `trig_acc` high at an edge gives `fill_stb` with only bit ~`trig_addr` set in the next cycle. The pulse lasts one cycle and matches `wr_addr`.
- R5: In test mode, a host write to address 0x04 (data ignored) gives `fill_stb` with only the test-pointer bit set in the next cycle.
- R6: In run mode, a host write to address 0x04 does not drive `fill_stb`.
- R7: In test mode, `trig_acc` does not drive `fill_stb`.
- R8: `rd_addr` one cycle after an edge equals `host_addr[5:4]` at that edge, whatever the cycle type and mode.
- R9: A host read (`host_sel`=1, `host_write`=0) with `host_addr[7:6]`=2'b10 drives `rd_en_n[k]` low for one cycle, where k = `host_addr[1:0]`, for k in 0..2. If k is 3 or the address is outside that window, all enables stay high.
- R10: A host write to the readout window asserts no readout enable.
- R11: A fill and a readout may target the same buffer in the same cycle. Each path then produces its own correct pointer, strobe and enable, and neither pointer is disturbed in later cycles.
- R12: `fill_stb` never has more than one bit set. Back-to-back accepts give back-to-back single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_acc | input | 1 | Level-1 accept from the trigger system |
| trig_addr | input | 2 | Buffer address from the trigger system |
| host_sel | input | 1 | Host cycle in progress |
| host_write | input | 1 | Host cycle is a write (1) or read (0) |
| host_addr | input | 8 | Host address |
| host_wdata | input | 3 | Host write data (control word) |
| wr_addr | output | 2 | Buffer being filled |
| fill_stb | output | 4 | One-hot fill strobe, one bit per buffer |
| rd_addr | output | 2 | Buffer selected for readout |
| rd_en_n | output | 3 | Active-low readout enables, one per tower pair |

## Verification
Every result lands exactly one cycle after the edge that samples its cause: pointer, fill strobe, read address and enables. The exception is a control-word write, whose effect on the pointer source appears one edge later, two cycles after the write. The bench's driver applies a stimulus at a falling edge and queues the outputs due after the next rising edge. The monitor pops one entry per rising edge, a short delay after it, so every comparison is tied to the cycle the requirements assign. Mode switches are checked on both sides of the two-cycle boundary.

// File: rtl/l2buf_pkg.sv
// Shared types and host address map for the level-2 buffer address control.
// Assumes a byte-granular host address of at least eight bits.
package l2buf_pkg;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_TEST = 1'b1
    } l2_mode_e;

    // Host address map (offsets in the low address space)
    localparam int CFG_OFS       = 'h00;
    localparam int FAKE_OFS      = 'h04;
    localparam int RD_REGION     = 2;   // value of the two top address bits
    localparam int BUF_FIELD_LSB = 4;   // readout buffer field position
    localparam int PAIR_W        = 2;   // tower-pair field at the address LSBs
    localparam int CFG_MODE_BIT  = 0;
    localparam int CFG_PTR_LSB   = 1;

    typedef struct packed {
        logic              cfg_wr;
        logic              fake_wr;
        logic              rd_cyc;
        logic [PAIR_W-1:0] pair;
    } host_dec_t;

endpackage

// File: rtl/l2_host_decode.sv
// Decodes one host cycle into control-word write, fake accept and readout
// read. Purely combinational; assumes host inputs are stable around the edge.
module l2_host_decode
    import l2buf_pkg::*;
#(
    parameter int HADDR_W = 8,
    parameter int NPAIR   = 3
) (
    input  logic               host_sel,
    input  logic               host_write,
    input  logic [HADDR_W-1:0] host_addr,
    output host_dec_t          dec
);

    localparam logic [HADDR_W-1:0] CFG_A  = HADDR_W'(CFG_OFS);
    localparam logic [HADDR_W-1:0] FAKE_A = HADDR_W'(FAKE_OFS);

    logic              in_window;
    logic [PAIR_W-1:0] pair_idx;

    // Classify the current host cycle
    always_comb begin
        in_window   = (host_addr[HADDR_W-1 -: 2] == 2'(RD_REGION));
        pair_idx    = host_addr[PAIR_W-1:0];
        dec.cfg_wr  = host_sel && host_write && (host_addr == CFG_A);
        dec.fake_wr = host_sel && host_write && (host_addr == FAKE_A);
        dec.rd_cyc  = host_sel && !host_write && in_window
                      && (int'(pair_idx) < NPAIR);
        dec.pair    = pair_idx;
    end

endmodule

// File: rtl/l2_wptr_sel.sv
// Holds the mode and test pointer, selects the fill pointer source and
// issues the one-hot fill strobe. Assumes NBUF is a power of two.
module l2_wptr_sel
    import l2buf_pkg::*;
#(
    parameter int NBUF  = 4,
    parameter int BA_W  = $clog2(NBUF),
    parameter int CFG_W = 1 + BA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             fake_wr,
    input  logic             trig_acc,
    input  logic [BA_W-1:0]  trig_addr,
    output logic [BA_W-1:0]  wr_addr,
    output logic [NBUF-1:0]  fill_stb,
    output logic             test_mode
);

    l2_mode_e        mode_q;
    logic [BA_W-1:0] tptr_q;
    logic [BA_W-1:0] sel_ptr;
    logic            fire;

    // Control word register: mode and test pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            tptr_q <= '0;
        end else if (cfg_wr) begin
            mode_q <= l2_mode_e'(cfg_word[CFG_MODE_BIT]);
            tptr_q <= cfg_word[CFG_PTR_LSB +: BA_W];
        end
    end

    // Pointer source and accept source follow the current mode
    always_comb begin
        test_mode = (mode_q == MODE_TEST);
        sel_ptr   = test_mode ? tptr_q : ~trig_addr;
        fire      = test_mode ? fake_wr : trig_acc;
    end

    // Registered fill pointer
    always_ff @(posedge clk) begin
        if (!rst_n) wr_addr <= '0;
        else        wr_addr <= sel_ptr;
    end

    // One strobe flop per buffer
    for (genvar i = 0; i < NBUF; i++) begin : g_fill
        always_ff @(posedge clk) begin
            if (!rst_n) fill_stb[i] <= 1'b0;
            else        fill_stb[i] <= fire && (sel_ptr == BA_W'(i));
        end
    end

endmodule

// File: rtl/l2_rd_port.sv
// Registers the readout buffer address and the per-pair active-low readout
// enables. Assumes the decode already qualified the read cycle.
module l2_rd_port
    import l2buf_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int BA_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BA_W-1:0]  buf_field,
    input  host_dec_t        dec,
    output logic [BA_W-1:0]  rd_addr,
    output logic [NPAIR-1:0] rd_en_n
);

    // Readout buffer address straight from the host field
    always_ff @(posedge clk) begin
        if (!rst_n) rd_addr <= '0;
        else        rd_addr <= buf_field;
    end

    // One active-low enable per tower pair
    for (genvar k = 0; k < NPAIR; k++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n) rd_en_n[k] <= 1'b1;
            else        rd_en_n[k] <= !(dec.rd_cyc && (dec.pair == PAIR_W'(k)));
        end
    end

endmodule

// File: rtl/l2_evbuf_addr_ctl.sv
// Top of the level-2 buffer address control: host decode, fill pointer
// selection and readout port. All outputs are registered, one cycle latency.
module l2_evbuf_addr_ctl
    import l2buf_pkg::*;
#(
    parameter int NBUF    = 4,
    parameter int NPAIR   = 3,
    parameter int HADDR_W = 8,
    parameter int BA_W    = $clog2(NBUF),
    parameter int CFG_W   = 1 + BA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_acc,
    input  logic [BA_W-1:0]    trig_addr,
    input  logic               host_sel,
    input  logic               host_write,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [CFG_W-1:0]   host_wdata,
    output logic [BA_W-1:0]    wr_addr,
    output logic [NBUF-1:0]    fill_stb,
    output logic [BA_W-1:0]    rd_addr,
    output logic [NPAIR-1:0]   rd_en_n
);

    host_dec_t dec;
    logic      test_mode;

    l2_host_decode #(
        .HADDR_W (HADDR_W),
        .NPAIR   (NPAIR)
    ) u_dec (
        .host_sel   (host_sel),
        .host_write (host_write),
        .host_addr  (host_addr),
        .dec        (dec)
    );

    l2_wptr_sel #(
        .NBUF  (NBUF),
        .BA_W  (BA_W),
        .CFG_W (CFG_W)
    ) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (dec.cfg_wr),
        .cfg_word  (host_wdata),
        .fake_wr   (dec.fake_wr),
        .trig_acc  (trig_acc),
        .trig_addr (trig_addr),
        .wr_addr   (wr_addr),
        .fill_stb  (fill_stb),
        .test_mode (test_mode)
    );

    l2_rd_port #(
        .NPAIR (NPAIR),
        .BA_W  (BA_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_field (host_addr[BUF_FIELD_LSB +: BA_W]),
        .dec       (dec),
        .rd_addr   (rd_addr),
        .rd_en_n   (rd_en_n)
    );

endmodule

// File: rtl/l2_evbuf_addr_ctl_chk.sv
// Property checker for the level-2 buffer address control, bound to the top.
// Observes ports and the internal mode flag only.
module l2_evbuf_addr_ctl_chk
    import l2buf_pkg::*;
#(
    parameter int NBUF    = 4,
    parameter int NPAIR   = 3,
    parameter int HADDR_W = 8,
    parameter int BA_W    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trig_acc,
    input logic [BA_W-1:0]    trig_addr,
    input logic               host_sel,
    input logic               host_write,
    input logic [HADDR_W-1:0] host_addr,
    input logic [BA_W-1:0]    wr_addr,
    input logic [NBUF-1:0]    fill_stb,
    input logic [BA_W-1:0]    rd_addr,
    input logic [NPAIR-1:0]   rd_en_n,
    input logic               test_mode
);

    logic fake_seen;
    logic rd_hit;
    assign fake_seen = host_sel && host_write && (host_addr == HADDR_W'(FAKE_OFS));
    assign rd_hit    = host_sel && !host_write
                       && (host_addr[HADDR_W-1 -: 2] == 2'(RD_REGION))
                       && (int'(host_addr[PAIR_W-1:0]) < NPAIR);

    // R2
    run_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> wr_addr == ~$past(trig_addr));

    // R4
    fill_matches_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_stb != '0) |-> fill_stb == (NBUF'(1) << wr_addr));

    // R6
    fake_ignored_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !trig_acc) |=> fill_stb == '0);

    // R7
    trig_ignored_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !fake_seen) |=> fill_stb == '0);

    // R8
    rd_addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rd_addr == $past(host_addr[BUF_FIELD_LSB +: BA_W]));

    // R9
    rd_en_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> $countones(~rd_en_n) == 1);

    // R10
    no_wr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_write) |=> rd_en_n == '1);

    // R12
    fill_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_stb));

endmodule

bind l2_evbuf_addr_ctl l2_evbuf_addr_ctl_chk #(
    .NBUF    (NBUF),
    .NPAIR   (NPAIR),
    .HADDR_W (HADDR_W),
    .BA_W    (BA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_acc   (trig_acc),
    .trig_addr  (trig_addr),
    .host_sel   (host_sel),
    .host_write (host_write),
    .host_addr  (host_addr),
    .wr_addr    (wr_addr),
    .fill_stb   (fill_stb),
    .rd_addr    (rd_addr),
    .rd_en_n    (rd_en_n),
    .test_mode  (test_mode)
);

// File: tb/tb_l2_evbuf_addr_ctl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected outputs, the monitor compares.
module tb_l2_evbuf_addr_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_acc = 1'b0;
    logic [1:0] trig_addr = 2'b00;
    logic       host_sel = 1'b0;
    logic       host_write = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [2:0] host_wdata = 3'b000;
    logic [1:0] wr_addr;
    logic [3:0] fill_stb;
    logic [1:0] rd_addr;
    logic [2:0] rd_en_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] wr;
        logic [3:0] fill;
        logic [1:0] rd;
        logic [2:0] en_n;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;

    // Bench model of the host-visible state
    logic       m_test = 1'b0;
    logic [1:0] m_ptr  = 2'b00;

    always #10 clk = ~clk;

    l2_evbuf_addr_ctl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_acc   (trig_acc),
        .trig_addr  (trig_addr),
        .host_sel   (host_sel),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .wr_addr    (wr_addr),
        .fill_stb   (fill_stb),
        .rd_addr    (rd_addr),
        .rd_en_n    (rd_en_n)
    );

    // Driver: apply one cycle of stimulus and queue what is due after the edge
    task automatic step(input logic acc, input logic [1:0] trig, input logic sel,
                        input logic wr, input logic [7:0] addr,
                        input logic [2:0] data, input string req);
        exp_t e;
        logic fake;
        logic cfgw;
        logic fire;
        @(negedge clk);
        trig_acc   = acc;
        trig_addr  = trig;
        host_sel   = sel;
        host_write = wr;
        host_addr  = addr;
        host_wdata = data;
        fake = sel && wr && (addr == 8'h04);
        cfgw = sel && wr && (addr == 8'h00);
        e.wr   = m_test ? m_ptr : ~trig;
        fire   = m_test ? fake : acc;
        e.fill = fire ? (4'b0001 << e.wr) : 4'b0000;
        e.rd   = addr[5:4];
        e.en_n = 3'b111;
        if (sel && !wr && addr[7:6] == 2'b10 && addr[1:0] != 2'b11)
            e.en_n[addr[1:0]] = 1'b0;
        e.req = req;
        if (cfgw) begin
            m_test = data[0];
            m_ptr  = data[2:1];
        end
        exp_q.push_back(e);
    endtask

    task automatic idle(input string req);
        step(1'b0, trig_addr, 1'b0, 1'b0, host_addr, 3'b000, req);
    endtask

    // Monitor: compare one queued item just after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            checks++;
            if (wr_addr !== mon_e.wr || fill_stb !== mon_e.fill ||
                rd_addr !== mon_e.rd || rd_en_n !== mon_e.en_n) begin
                fails++;
                $display("FAIL %s: actual wr=%0d fill=%b rd=%0d en_n=%b expected wr=%0d fill=%b rd=%0d en_n=%b",
                         mon_e.req, wr_addr, fill_stb, rd_addr, rd_en_n,
                         mon_e.wr, mon_e.fill, mon_e.rd, mon_e.en_n);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual run not finished expected finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        checks++;
        if (wr_addr !== 2'd0 || fill_stb !== 4'b0 || rd_addr !== 2'd0 || rd_en_n !== 3'b111) begin
            fails++;
            $display("FAIL R1: actual wr=%0d fill=%b rd=%0d en_n=%b expected wr=0 fill=0000 rd=0 en_n=111",
                     wr_addr, fill_stb, rd_addr, rd_en_n);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step(1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 3'b000, "R2 run pointer inverted");
        step(1'b1, 2'd1, 1'b0, 1'b0, 8'h00, 3'b000, "R4 run accept fills buffer 2");
        step(1'b1, 2'd2, 1'b0, 1'b0, 8'h00, 3'b000, "R12 back-to-back accept");
        step(1'b0, 2'd3, 1'b1, 1'b1, 8'h04, 3'b000, "R6 fake accept in run mode");
        step(1'b0, 2'd3, 1'b1, 1'b0, 8'h90, 3'b000, "R9 read pair 0");
        step(1'b0, 2'd3, 1'b1, 1'b0, 8'h92, 3'b000, "R9 read pair 2");
        step(1'b0, 2'd3, 1'b1, 1'b0, 8'hB3, 3'b000, "R9 pair index 3 no enable");
        step(1'b0, 2'd3, 1'b1, 1'b1, 8'h91, 3'b000, "R10 write to readout window");
        step(1'b0, 2'd3, 1'b1, 1'b0, 8'h50, 3'b000, "R8 read outside window");
        step(1'b0, 2'd0, 1'b1, 1'b1, 8'h00, 3'b101, "R3 config write, still run");
        step(1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 3'b000, "R3 test pointer 2 visible");
        step(1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 3'b000, "R7 trigger accept in test mode");
        step(1'b0, 2'd0, 1'b1, 1'b1, 8'h04, 3'b000, "R5 fake accept fills buffer 2");
        step(1'b0, 2'd0, 1'b1, 1'b1, 8'h00, 3'b111, "R3 change test pointer");
        step(1'b0, 2'd0, 1'b1, 1'b1, 8'h04, 3'b010, "R5 fake accept fills buffer 3");
        step(1'b0, 2'd0, 1'b1, 1'b1, 8'h00, 3'b000, "R3 back to run mode");
        step(1'b1, 2'd1, 1'b1, 1'b0, 8'hA1, 3'b000, "R11 fill and read buffer 2");
        step(1'b1, 2'd1, 1'b1, 1'b0, 8'hA1, 3'b000, "R11 repeat same buffer");
        step(1'b0, 2'd1, 1'b1, 1'b0, 8'hA0, 3'b000, "R11 pointers undisturbed");
        idle("R8 idle after traffic");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule